// File: doc/BRIEF.md
# Non-retriggerable pulse-burst regenerator

This block turns one clean rising edge on a noisy trigger line into a fixed, internally timed burst of pulses on a single emitter output. The trigger is first passed through a two-stage synchronizer. A rising edge is then detected by comparing the synchronized level with its value one cycle earlier. The block starts a burst only when it is idle. During the burst it drives `emit_out` high for `HIGH_CYC` cycles, then low for `LOW_CYC` cycles, and repeats this `PULSE_CNT` times. Every trigger edge that arrives while the burst runs is ignored.

When the last high phase ends, a lockout period of `LOCK_CYC` cycles begins. This period also covers the low gap that would follow the final pulse. Trigger activity is still ignored during lockout, so the noisy input has time to settle. After lockout the block re-arms and waits for a fresh rising edge. `busy_out` is high for the whole burst and the whole lockout. The defaults assume an 8 MHz clock:
- high phase: 12160 cycles (1.52 ms)
- low phase: 10880 cycles (1.36 ms)
- lockout: 50880 cycles (1.36 ms gap plus 5 ms)
- pulse count: 4

With these values, burst plus lockout fits inside the trigger's own repetition frame.

The state machine has four states: IDLE (armed, output low), HIGH (pulse on), LOW (gap between pulses) and LOCK (lockout). It has five transitions:
- START: IDLE to HIGH on a detected rising edge.
- NEXT_GAP: HIGH to LOW when the high time expires and pulses remain.
- LAST_PULSE: HIGH to LOCK when the high time of the final pulse expires.
- NEXT_PULSE: LOW to HIGH when the gap expires.
- REARM: LOCK to IDLE when the lockout expires.

A synchronous reset forces IDLE from any state.

Top module: `pulse_burst_regen`

## Requirements
- R1: From IDLE, a 0-to-1 change of `trig_in` makes `emit_out` and `busy_out` rise at the third rising clock edge, counting as the first the edge that samples `trig_in` high (two synchronizer stages plus one state update). A burst always opens with a high phase.
- R2: Every high phase of `emit_out` lasts exactly `HIGH_CYC` clock cycles.
- R3: Between two pulses of the same burst, `emit_out` is low for exactly `LOW_CYC` cycles.
- R4: A burst contains exactly `PULSE_CNT` pulses, and `emit_out` stays low after the last one.
- R5: Any trigger activity (edges, glitches, toggling) during a burst neither restarts nor alters it.
- R6: Lockout lasts exactly `LOCK_CYC` cycles, starting the cycle after the last high phase ends. During lockout `busy_out` is high, `emit_out` is low, and trigger edges are ignored.
- R7: After lockout the block is re-armed, and only a new 0-to-1 change starts the next burst. A trigger held high across re-arming starts nothing.
- R8: `busy_out` is high exactly from the first high cycle of a burst to the last lockout cycle.
- R9: While `rst` is high at a clock edge, the block returns to IDLE with both outputs low and the synchronizer cleared. A trigger that is high when reset is released is therefore seen as a new rising edge.
- R10: `emit_out` is never high while `busy_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock (8 MHz for the default counts) |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous, possibly noisy trigger |
| emit_out | output | 1 | Regenerated pulse train to the emitter driver |
| busy_out | output | 1 | High during a burst and its lockout |

## Verification
A trigger value driven between clock edges is sampled by the first edge and shows on the outputs after the third. The bench therefore records each driven value in a short history. It treats a rise driven at step j as accepted only if its reference model was idle at step j+2, and then expects the burst's first high cycle at step j+3. From that start index, the expected `emit_out` and `busy_out` for every later step follow from the phase arithmetic: position modulo `HIGH_CYC+LOW_CYC`, burst length, and lockout length. Both outputs are compared at every falling edge, before the next input is driven. A sweep places a second edge at every offset through the burst, the lockout and a few cycles past re-arm, so the boundary cycle where the edge first counts is checked exactly.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_LOCK = 2'd3
    } burst_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pbr_sync_edge.sv
module pbr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pbr_down_timer.sv
module pbr_down_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/pbr_burst_fsm.sv
module pbr_burst_fsm
    import pbr_pkg::*;
#(
    parameter int HIGH_CYC  = 12160,
    parameter int LOW_CYC   = 10880,
    parameter int LOCK_CYC  = 50880,
    parameter int PULSE_CNT = 4,
    parameter int CW        = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_seen,
    input  logic          phase_expired,
    output logic          phase_load,
    output logic [CW-1:0] phase_len,
    output logic          emit_out,
    output logic          busy_out
);
    localparam int PW = $clog2(PULSE_CNT + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(PULSE_CNT - 1);
    localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] LOCK_LD  = CW'(LOCK_CYC - 1);

    burst_state_t  cur_st, nxt_st;
    logic [PW-1:0] pulse_idx, pulse_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st    <= ST_IDLE;
            pulse_idx <= '0;
        end else begin
            cur_st    <= nxt_st;
            pulse_idx <= pulse_nxt;
        end
    end

    // Transitions: START, NEXT_GAP, LAST_PULSE, NEXT_PULSE, REARM
    always_comb begin
        nxt_st     = cur_st;
        pulse_nxt  = pulse_idx;
        phase_load = 1'b0;
        phase_len  = '0;
        unique case (cur_st)
            ST_IDLE: begin
                if (edge_seen) begin          // START
                    nxt_st     = ST_HIGH;
                    phase_load = 1'b1;
                    phase_len  = HIGH_LD;
                end
            end
            ST_HIGH: begin
                if (phase_expired) begin
                    phase_load = 1'b1;
                    if (pulse_idx == LAST_IDX) begin   // LAST_PULSE
                        nxt_st    = ST_LOCK;
                        phase_len = LOCK_LD;
                        pulse_nxt = '0;
                    end else begin                     // NEXT_GAP
                        nxt_st    = ST_LOW;
                        phase_len = LOW_LD;
                        pulse_nxt = pulse_idx + PW'(1);
                    end
                end
            end
            ST_LOW: begin
                if (phase_expired) begin      // NEXT_PULSE
                    nxt_st     = ST_HIGH;
                    phase_load = 1'b1;
                    phase_len  = HIGH_LD;
                end
            end
            ST_LOCK: begin
                if (phase_expired) begin      // REARM
                    nxt_st = ST_IDLE;
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        emit_out = (cur_st == ST_HIGH);
        busy_out = (cur_st != ST_IDLE);
    end
endmodule

// File: rtl/pulse_burst_regen.sv
module pulse_burst_regen #(
    parameter int HIGH_CYC    = 12160,
    parameter int LOW_CYC     = 10880,
    parameter int LOCK_CYC    = 50880,
    parameter int PULSE_CNT   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic emit_out,
    output logic busy_out
);
    localparam int MAX_CYC = pbr_pkg::max3(HIGH_CYC, LOW_CYC, LOCK_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic          trig_rise;
    logic          phase_load;
    logic [CW-1:0] phase_len;
    logic          phase_expired;

    pbr_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_sync_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    pbr_down_timer #(
        .CW(CW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (phase_load),
        .load_val (phase_len),
        .expired  (phase_expired)
    );

    pbr_burst_fsm #(
        .HIGH_CYC  (HIGH_CYC),
        .LOW_CYC   (LOW_CYC),
        .LOCK_CYC  (LOCK_CYC),
        .PULSE_CNT (PULSE_CNT),
        .CW        (CW)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .edge_seen     (trig_rise),
        .phase_expired (phase_expired),
        .phase_load    (phase_load),
        .phase_len     (phase_len),
        .emit_out      (emit_out),
        .busy_out      (busy_out)
    );
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
    parameter int HIGH_CYC  = 12160,
    parameter int LOW_CYC   = 10880,
    parameter int LOCK_CYC  = 50880,
    parameter int PULSE_CNT = 4
) (
    input logic clk,
    input logic rst,
    input logic trig_rise,
    input logic emit_out,
    input logic busy_out
);
    logic [31:0] hi_run, lo_run, pulses;
    logic        emit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
            pulses <= '0;
            emit_q <= 1'b0;
        end else begin
            emit_q <= emit_out;
            hi_run <= emit_out ? hi_run + 32'd1 : 32'd0;
            lo_run <= (busy_out && !emit_out) ? lo_run + 32'd1 : 32'd0;
            if (!busy_out)
                pulses <= '0;
            else if (emit_out && !emit_q)
                pulses <= pulses + 32'd1;
        end
    end

    // R1: a burst only begins after a detected edge, and begins high
    p_start_needs_edge_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_out) |-> $past(trig_rise));
    p_start_high_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_out) |-> emit_out);
    // R2
    p_high_len_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(emit_out) && !$past(rst)) |-> (hi_run == 32'(HIGH_CYC)));
    // R3
    p_gap_len_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(emit_out) && $past(busy_out)) |-> (lo_run == 32'(LOW_CYC)));
    // R4
    p_pulse_count_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_out) && !$past(rst)) |-> (pulses == 32'(PULSE_CNT)));
    // R6
    p_lock_len_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_out) && !$past(rst)) |-> (lo_run == 32'(LOCK_CYC)));
    // R9
    p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!emit_out && !busy_out));
    // R10
    p_emit_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        emit_out |-> busy_out);
endmodule

bind pulse_burst_regen pbr_checker #(
    .HIGH_CYC  (HIGH_CYC),
    .LOW_CYC   (LOW_CYC),
    .LOCK_CYC  (LOCK_CYC),
    .PULSE_CNT (PULSE_CNT)
) u_pbr_checker (
    .clk       (clk),
    .rst       (rst),
    .trig_rise (trig_rise),
    .emit_out  (emit_out),
    .busy_out  (busy_out)
);

// File: tb/test_pulse_burst_regen.sv
module test_pulse_burst_regen;
    localparam int H   = 5;
    localparam int L   = 3;
    localparam int K   = 7;
    localparam int P   = 3;
    localparam int PER = H + L;
    localparam int BL  = P * H + (P - 1) * L;
    localparam int TOT = BL + K;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic emit, busy;

    pulse_burst_regen #(
        .HIGH_CYC(H), .LOW_CYC(L), .LOCK_CYC(K), .PULSE_CNT(P), .SYNC_STAGES(2)
    ) i_pulse_burst_regen (
        .clk(clk), .rst(rst), .trig_in(trig), .emit_out(emit), .busy_out(busy)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int n = 0;
    int start_n = 0;
    int rises = 0;
    bit has_start = 0;
    bit h1 = 0, h2 = 0, h3 = 0, h4 = 0;
    bit emit_prev = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d step=%0d", tag, act, exp, n);
        end
    endtask

    // Sample at the falling edge, compare with the arithmetic model, then drive.
    task automatic step(input bit t);
        int rel;
        bit act, exp_e;
        string te, tb;
        @(negedge clk);
        if (h3 && !h4) begin
            if (!has_start || (n - 1 - start_n >= TOT)) begin
                has_start = 1;
                start_n = n;
            end
        end
        rel   = has_start ? (n - start_n) : -1;
        act   = has_start && (rel < TOT);
        exp_e = act && (rel < BL) && ((rel % PER) < H);
        if (!act) te = has_start ? "R7" : "R1";
        else if (rel < BL) te = ((rel % PER) < H) ? "R2" : "R3";
        else te = "R4";
        if (!act && has_start) tb = "R7";
        else if (act && rel >= BL) tb = "R6";
        else tb = "R8";
        chk(emit == exp_e, te, int'(emit), int'(exp_e));
        chk(busy == act, tb, int'(busy), int'(act));
        chk(!(emit && !busy), "R10", int'(emit), 0);
        if (emit && !emit_prev) rises++;
        emit_prev = emit;
        trig = t;
        h4 = h3; h3 = h2; h2 = h1; h1 = t;
        n++;
    endtask

    task automatic reset_dut(input bit tv);
        @(negedge clk);
        rst = 1'b1;
        trig = tv;
        repeat (3) @(negedge clk);
        chk(emit == 1'b0, "R9", int'(emit), 0);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        rst = 1'b0;
        trig = tv;
        h1 = tv; h2 = 0; h3 = 0; h4 = 0;
        has_start = 0;
        n = 0;
        emit_prev = 0;
    endtask

    task automatic idle_for(input int c);
        for (int i = 0; i < c; i++) step(1'b0);
    endtask

    initial begin
        int r0;
        reset_dut(1'b0);

        // Clean two-cycle trigger: one complete burst (R1, R4)
        r0 = rises;
        step(1'b1); step(1'b1);
        idle_for(TOT + 6);
        chk(rises - r0 == P, "R4", rises - r0, P);

        // Trigger toggling throughout burst and lockout (R5)
        r0 = rises;
        step(1'b1);
        for (int i = 1; i < TOT; i++) step(i[0]);
        idle_for(TOT + 6);
        chk(rises - r0 == P, "R5", rises - r0, P);

        // Second edge swept across burst, lockout and re-arm boundary (R5, R6, R7)
        for (int d = 2; d <= TOT + 5; d++) begin
            step(1'b1);
            for (int i = 1; i < d; i++) step(1'b0);
            step(1'b1);
            step(1'b0);
            idle_for(2 * TOT + 8);
        end

        // Trigger held high across re-arm: a single burst only (R7)
        r0 = rises;
        for (int i = 0; i < 2 * TOT + 10; i++) step(1'b1);
        idle_for(TOT + 6);
        chk(rises - r0 == P, "R7", rises - r0, P);

        // Reset in mid-burst with trigger high: synchronizer cleared (R9)
        step(1'b1);
        idle_for(10);
        reset_dut(1'b1);
        r0 = rises;
        for (int i = 0; i < TOT + 6; i++) step(1'b1);
        idle_for(6);
        chk(rises - r0 == P, "R9", rises - r0, P);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule